// File: doc/BRIEF.md
# Lockout-Free Five-State Sequence Counter

This block is a synchronous 3-bit counter that visits five codes in a fixed order: 1, 4, 5, 6, 7, and then back to 1. It does not count in binary order. All state flip-flops share one clock, so every output bit changes on the same edge. A count-enable input advances the sequence. When enable is low, the counter holds its code.

Three of the eight codes (0, 2 and 3) are not in the sequence. If one of them appears, the next-state logic sends it to code 1 on the next clock edge, whatever the enable input is. A pass through the unused codes therefore never lasts more than one cycle, and the counter cannot lock out.

A registered flag reports each such correction. It is high for one cycle, in the same cycle that code 1 is restored.

A parameter sets the code that reset loads. Its default is 1. Other values let a unit start from a chosen code, including an unused one, so that the correction path can be exercised from the ports.

Top module: `lockfree_seq_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes `INIT_CODE` (default 1) and `fix_o` becomes 0.
- R2: With `cnt_en` high, a rising edge moves a used state to its successor: 1 to 4, 4 to 5, 5 to 6, 6 to 7, and 7 back to 1.
- R3: With `cnt_en` low, a rising edge leaves a used state (1, 4, 5, 6 or 7) unchanged.
- R4: The unused codes 0, 2 and 3 go to code 1 on the next rising edge, whatever the level of `cnt_en`.
- R5: `fix_o` is 1 in the cycle right after a cycle whose state was an unused code, and 0 after any cycle whose state was a used code.
- R6: The state never holds an unused code for two consecutive cycles outside reset.
- R7: With `INIT_CODE` set to an unused code, that code is visible on `state_o` while reset is held, and `fix_o` stays 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all state flip-flops |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Advances a used state when high |
| state_o | output | 3 | Current counter code |
| fix_o | output | 1 | One-cycle pulse after an unused code was corrected |

## Verification
The main unit is driven with enable patterns that mix runs of counting with held cycles, including a hold on 7 and a wrap from 7 to 1. This separates the custom successor order from plain holding and from a binary count. Three extra units start from codes 0, 2 and 3, and each is released once with enable low and once with enable high. The first release shows that correction does not depend on enable. The second shows that an unused code goes to 1 and not to a successor. The flag is checked both in the correction cycle and in the cycle after it, which tells a one-cycle pulse from a sticky level. A reset in the middle of the sequence shows that reset overrides counting.

// File: rtl/lfs_pkg.sv
// Package: shared width and sequence definitions for the lockout-free counter.
// Assumes a 3-bit code space in which the used sequence is 1,4,5,6,7.
package lfs_pkg;
    localparam int CW      = 3;
    localparam int NCODES  = 1 << CW;
    localparam logic [CW-1:0] HOME = 3'd1;
    // bit n set means code n belongs to the used sequence
    localparam logic [NCODES-1:0] USED_MASK = 8'b1111_0010;

    // Successor of a used code; unused codes map to HOME.
    function automatic logic [CW-1:0] succ(input logic [CW-1:0] c);
        case (c)
            3'd1:    succ = 3'd4;
            3'd4:    succ = 3'd5;
            3'd5:    succ = 3'd6;
            3'd6:    succ = 3'd7;
            3'd7:    succ = 3'd1;
            default: succ = HOME;
        endcase
    endfunction
endpackage

// File: rtl/lfs_used_decode.sv
// Module: decodes whether the current code belongs to the used sequence.
// Assumes the mask parameter marks used codes with a 1.
module lfs_used_decode #(
    parameter int W = lfs_pkg::CW,
    parameter logic [(1<<W)-1:0] MASK = lfs_pkg::USED_MASK
) (
    input  logic [W-1:0] cur_i,
    output logic         used_o
);
    localparam int N = 1 << W;
    logic [N-1:0] hit;

    // one match term per code that the mask marks as used
    for (genvar c = 0; c < N; c++) begin : g_code
        assign hit[c] = MASK[c] && (cur_i == W'(c));
    end

    // used when any marked code matches
    always_comb used_o = |hit;
endmodule

// File: rtl/lfs_next_state.sv
// Module: next-state selection for the lockout-free counter.
// Assumes used_i comes from the used-code decoder for cur_i.
module lfs_next_state #(
    parameter int W = lfs_pkg::CW
) (
    input  logic [W-1:0] cur_i,
    input  logic         en_i,
    input  logic         used_i,
    output logic [W-1:0] nxt_o
);
    // unused codes go home; used codes advance or hold
    always_comb begin
        if (!used_i)
            nxt_o = lfs_pkg::HOME;
        else if (en_i)
            nxt_o = lfs_pkg::succ(cur_i);
        else
            nxt_o = cur_i;
    end
endmodule

// File: rtl/lockfree_seq_counter.sv
// Module: 3-bit counter over 1,4,5,6,7 with forced recovery of unused codes.
// Assumes a single clock; synchronous active-low reset loads INIT_CODE.
module lockfree_seq_counter #(
    parameter logic [2:0] INIT_CODE = lfs_pkg::HOME
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    output logic [2:0] state_o,
    output logic       fix_o
);
    localparam int W = lfs_pkg::CW;

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic         used;
    logic         fix_q;

    lfs_used_decode #(.W(W), .MASK(lfs_pkg::USED_MASK)) u_dec (
        .cur_i (state_q),
        .used_o(used)
    );

    lfs_next_state #(.W(W)) u_nxt (
        .cur_i (state_q),
        .en_i  (cnt_en),
        .used_i(used),
        .nxt_o (state_d)
    );

    // state register: reset loads the init code, otherwise take next state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= INIT_CODE;
        else        state_q <= state_d;
    end

    // correction flag: registered marker of an unused code just left
    always_ff @(posedge clk) begin
        if (!rst_n) fix_q <= 1'b0;
        else        fix_q <= !used;
    end

    assign state_o = state_q;
    assign fix_o   = fix_q;

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> (state_o == INIT_CODE) && !fix_o);

    // R2
    wrap_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd7 && cnt_en) |=> state_o == 3'd1);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && cnt_en) |=> state_o == 3'd4);

    // R3
    hold_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used && !cnt_en) |=> $stable(state_o));

    // R4
    unused_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd2 || state_o == 3'd3) |=> state_o == 3'd1);

    // R5
    fix_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !used |=> fix_o);

    // R5
    fix_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used |=> !fix_o);

    // R6
    no_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !used |=> used);
endmodule

// File: tb/test_lockfree_seq_counter.sv
`timescale 1ns/1ps
module test_lockfree_seq_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic rst_x = 1'b0;
    logic en_x = 1'b0;
    logic [2:0] st_m, st_0, st_2, st_3;
    logic fx_m, fx_0, fx_2, fx_3;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lockfree_seq_counter i_lockfree_seq_counter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .state_o(st_m), .fix_o(fx_m));
    lockfree_seq_counter #(.INIT_CODE(3'd0)) i_lockfree_seq_counter_u0 (
        .clk(clk), .rst_n(rst_x), .cnt_en(en_x), .state_o(st_0), .fix_o(fx_0));
    lockfree_seq_counter #(.INIT_CODE(3'd2)) i_lockfree_seq_counter_u2 (
        .clk(clk), .rst_n(rst_x), .cnt_en(en_x), .state_o(st_2), .fix_o(fx_2));
    lockfree_seq_counter #(.INIT_CODE(3'd3)) i_lockfree_seq_counter_u3 (
        .clk(clk), .rst_n(rst_x), .cnt_en(en_x), .state_o(st_3), .fix_o(fx_3));

    // each entry: {cnt_en, expected state after the edge, expected flag}
    localparam logic [4:0] VEC [13] = '{
        {1'b1, 3'd4, 1'b0}, {1'b1, 3'd5, 1'b0}, {1'b0, 3'd5, 1'b0},
        {1'b1, 3'd6, 1'b0}, {1'b1, 3'd7, 1'b0}, {1'b0, 3'd7, 1'b0},
        {1'b1, 3'd1, 1'b0}, {1'b0, 3'd1, 1'b0}, {1'b1, 3'd4, 1'b0},
        {1'b1, 3'd5, 1'b0}, {1'b1, 3'd6, 1'b0}, {1'b1, 3'd7, 1'b0},
        {1'b1, 3'd1, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_x(input string tag, input int s0, input int s2,
                           input int s3, input int f);
        check({tag, " u0 state"}, st_0, s0);
        check({tag, " u2 state"}, st_2, s2);
        check({tag, " u3 state"}, st_3, s3);
        check({tag, " u0 flag"}, fx_0, f);
        check({tag, " u2 flag"}, fx_2, f);
        check({tag, " u3 flag"}, fx_3, f);
    endtask

    initial begin
        tick();
        tick();
        check("R1 reset state", st_m, 1);
        check("R1 reset flag", fx_m, 0);
        check_x("R7 init held", 0, 2, 3, 0);

        rst_n = 1'b1;
        for (int i = 0; i < 13; i++) begin
            cnt_en = VEC[i][4];
            tick();
            check($sformatf("R2/R3 vec %0d state", i), st_m, VEC[i][3:1]);
            check($sformatf("R5 vec %0d flag", i), fx_m, VEC[i][0]);
        end

        // reset in the middle of the sequence overrides counting
        cnt_en = 1'b1;
        tick(); tick(); tick();
        check("R2 reach 6", st_m, 6);
        rst_n = 1'b0;
        tick();
        check("R1 mid reset state", st_m, 1);
        check("R1 mid reset flag", fx_m, 0);
        rst_n = 1'b1;

        // unused codes corrected with enable low
        rst_x = 1'b1; en_x = 1'b0;
        tick();
        check_x("R4 R5 fix en0", 1, 1, 1, 1);
        tick();
        check_x("R5 R6 after fix en0", 1, 1, 1, 0);

        // unused codes corrected with enable high: go to 1, not a successor
        rst_x = 1'b0;
        tick();
        check_x("R7 init again", 0, 2, 3, 0);
        rst_x = 1'b1; en_x = 1'b1;
        tick();
        check_x("R4 R5 fix en1", 1, 1, 1, 1);
        tick();
        check_x("R2 R5 after fix en1", 4, 4, 4, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule